// File: doc/BRIEF.md
# Serially Configured Clock Fan-out Gate

This block fans one reference clock out to ten outputs. Each output has its own enable bit. A bank of enable bits is loaded over a two-wire serial bus. The block is a receive-only slave on that bus. It watches an oversampled clock/data pair, answers its own device address, and acknowledges each byte it takes. It ignores a command byte and a count byte. It then loads up to seven data bytes, and only a few bits of those bytes reach an enable.

Each enable bit is committed as soon as its own bus clock pulse completes, so a host can stop a transfer part-way and leave every later bit untouched. Enable changes reach an output only while the reference clock is low, so no output ever produces a short pulse. A separate output-enable pin tri-states all ten outputs at once.

Top module: `clk_fanout_cfg`

## Requirements
- R1: A fall of SDA while SCL is high is a start. A rise of SDA while SCL is high is a stop. A data bit is the SDA level during an SCL high pulse, and it counts only when that pulse ends with SCL falling. Bus activity after a stop and before the next start has no effect and gets no acknowledge.
- R2: The first byte after a start is compared with the device address 8'b11010010. On a match, the slave pulls SDA low (sda_pull_o=1) during the ninth SCL pulse of that byte.
- R3: The slave also acknowledges the second and third bytes and data bytes 0 to 6. sda_pull_o changes only while SCL is low, except when a start or stop clears it.
- R4: A first byte other than 8'b11010010 gets no acknowledge. Until the next start, no enable changes and no acknowledge is given.
- R5: Bytes are received MSB first. The second byte (command) and third byte (count) are ignored. Data byte 0 is the fourth byte after the start.
- R6: Each enable bit takes its new value when its data bit is committed, before the rest of its byte arrives.
- R7: A stop or a repeated start ends a transfer at any bit. Enables not yet reached keep their values.
- R8: Data byte 0 bits 3..0 set enables 3..0. Data byte 1 bits 7..4 set enables 7..4. Data byte 2 bit 2 sets enable 8 and bit 3 sets enable 9. Every other bit, and data bytes 3 to 6, have no effect.
- R9: With its enable at 1, clk_out_o[i] equals ref_clk_i. With its enable at 0, it is held low. An enable change shows on the output only while ref_clk_i is low, so the output never changes during a high phase of ref_clk_i.
- R10: After reset all ten enables are 1.
- R11: clk_drive_o is all zeros while oe_i is 0 and all ones while oe_i is 1, whatever the enables hold.
- R12: A byte sent after data byte 6 gets no acknowledge and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial bus clock level |
| sda_i | input | 1 | Serial bus data level (wired bus value) |
| ref_clk_i | input | 1 | Reference clock that is fanned out |
| oe_i | input | 1 | Output-enable pin, high to drive outputs |
| sda_pull_o | output | 1 | 1 = pull the SDA line low (open-drain acknowledge) |
| clk_out_o | output | 10 | Gated copies of the reference clock |
| clk_drive_o | output | 10 | Per-output driver enable; 0 = tri-stated |

## Verification
The bench builds the block with its default parameters: ten outputs, seven data bytes, two synchronizer stages and address 8'hD2. The bus runs at six system clocks per SCL half period, and the reference clock is unrelated to the system clock. With these settings, random transfers can reach every byte position, including the one past data byte 6. Truncation can land on any bit and ack slot, and enable writes land at arbitrary phases of the reference clock. This is how the no-short-pulse rule gets exercised.

// File: rtl/clk_fanout_pkg.sv
// Shared types and the output-to-register-bit map for the clock fan-out gate.
// Assumes exactly ten outputs, placed over three data bytes.
package clk_fanout_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_RECV = 2'd1,
        RX_SKIP = 2'd2
    } rx_state_t;

    // Data byte that holds the enable of output idx.
    function automatic int unsigned en_byte_of(input int unsigned idx);
        if (idx < 4)      return 0;
        else if (idx < 8) return 1;
        else              return 2;
    endfunction

    // Bit position inside that byte: outputs 0..7 use their own index, 8 and 9 use bits 2 and 3.
    function automatic int unsigned en_bit_of(input int unsigned idx);
        if (idx < 8) return idx;
        else         return idx - 6;
    endfunction

    // True when a (byte, bit) pair controls some output.
    function automatic logic bit_is_mapped(input logic [2:0] byt, input logic [2:0] bt);
        logic hit;
        hit = 1'b0;
        for (int unsigned i = 0; i < 10; i++)
            if (byt == 3'(en_byte_of(i)) && bt == 3'(en_bit_of(i))) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/bus_cond_detect.sv
// Synchronizes the serial bus pair to clk and reports SCL edges and start/stop conditions.
// Assumes the SCL half period spans several clk cycles.
module bus_cond_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_prev;
    logic                   sda_prev;

    // Shift raw bus levels through the synchronizer chain; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh   <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_sh[SYNC_STAGES-1];
            sda_prev <= sda_sh[SYNC_STAGES-1];
        end
    end

    // Decode edges and bus conditions from current and previous synchronized levels.
    always_comb begin
        scl_hi_o   = scl_sh[SYNC_STAGES-1];
        sda_lvl_o  = sda_sh[SYNC_STAGES-1];
        scl_rise_o = scl_hi_o & ~scl_prev;
        scl_fall_o = ~scl_hi_o & scl_prev;
        start_o    = scl_hi_o & scl_prev & sda_prev & ~sda_lvl_o;
        stop_o     = scl_hi_o & scl_prev & ~sda_prev & sda_lvl_o;
    end

endmodule

// File: rtl/cfg_rx_fsm.sv
// Write-only serial slave: checks the address, skips the dummy bytes, acknowledges
// and emits one write strobe per committed data bit.
// Assumes bus events come from bus_cond_detect. A bit is latched on the SCL rise and
// committed on the SCL fall, so a start or stop in the high phase never commits it.
module cfg_rx_fsm
    import clk_fanout_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR    = 8'hD2,
    parameter int         DUMMY_BYTES = 2,
    parameter int         DATA_BYTES  = 7,
    parameter int         BYTE_W      = $clog2(DATA_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_hi_i,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              ack_low_o,
    output logic              wr_valid_o,
    output logic [BYTE_W-1:0] wr_byte_o,
    output logic [2:0]        wr_bit_o,
    output logic              wr_val_o
);

    localparam int LAST_IDX = DUMMY_BYTES + DATA_BYTES;
    localparam int CNT_W    = $clog2(LAST_IDX + 2);
    localparam logic [CNT_W-1:0] FIRST_DATA_C = CNT_W'(DUMMY_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_DATA_C  = CNT_W'(LAST_IDX);

    rx_state_t        state;
    logic [3:0]       bit_idx;
    logic [CNT_W-1:0] byte_idx;
    logic [7:0]       shreg;
    logic             sda_hold;
    logic             have_bit;
    logic             accept;
    logic             in_data;

    // Decide whether the byte now closing gets an acknowledge.
    always_comb begin
        in_data = (byte_idx >= FIRST_DATA_C) && (byte_idx <= LAST_DATA_C);
        if (byte_idx == '0) accept = ({shreg[6:0], sda_hold} == DEV_ADDR);
        else                accept = (byte_idx <= LAST_DATA_C);
    end

    // Receive sequencer: bit/byte counting, ack drive and per-bit write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            bit_idx    <= '0;
            byte_idx   <= '0;
            shreg      <= '0;
            sda_hold   <= 1'b1;
            have_bit   <= 1'b0;
            ack_low_o  <= 1'b0;
            wr_valid_o <= 1'b0;
            wr_byte_o  <= '0;
            wr_bit_o   <= '0;
            wr_val_o   <= 1'b0;
        end else begin
            wr_valid_o <= 1'b0;
            if (start_i) begin
                state     <= RX_RECV;
                bit_idx   <= '0;
                byte_idx  <= '0;
                have_bit  <= 1'b0;
                ack_low_o <= 1'b0;
            end else if (stop_i) begin
                state     <= RX_IDLE;
                have_bit  <= 1'b0;
                ack_low_o <= 1'b0;
            end else if (state == RX_RECV) begin
                if (scl_rise_i) begin
                    sda_hold <= sda_lvl_i;
                    have_bit <= 1'b1;
                end
                if (scl_fall_i && have_bit) begin
                    have_bit <= 1'b0;
                    if (bit_idx == 4'd8) begin
                        ack_low_o <= 1'b0;
                        bit_idx   <= '0;
                        byte_idx  <= byte_idx + 1'b1;
                    end else begin
                        shreg <= {shreg[6:0], sda_hold};
                        if (in_data) begin
                            wr_valid_o <= 1'b1;
                            wr_byte_o  <= BYTE_W'(byte_idx - FIRST_DATA_C);
                            wr_bit_o   <= 3'd7 - bit_idx[2:0];
                            wr_val_o   <= sda_hold;
                        end
                        if (bit_idx == 4'd7) begin
                            if (accept) begin
                                ack_low_o <= 1'b1;
                                bit_idx   <= 4'd8;
                            end else begin
                                state <= RX_SKIP;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
            end
        end
    end

    AST_ACK_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_low_o) |-> (!scl_hi_i || $past(start_i || stop_i))); // R3
    AST_SKIP_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_SKIP) |-> !ack_low_o); // R4
    AST_COMMIT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> !scl_hi_i); // R1

endmodule

// File: rtl/en_bank.sv
// Holds one enable bit per output and updates it from single-bit write strobes.
// Assumes at most one strobe per cycle; reserved positions match no output.
module en_bank
    import clk_fanout_pkg::*;
#(
    parameter int NUM_OUT = 10,
    parameter int BYTE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid_i,
    input  logic [BYTE_W-1:0]  wr_byte_i,
    input  logic [2:0]         wr_bit_i,
    input  logic               wr_val_i,
    output logic [NUM_OUT-1:0] en_o
);

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_en
        localparam int unsigned BY = en_byte_of(g);
        localparam int unsigned BI = en_bit_of(g);
        // Load this output's enable when its own (byte, bit) is written; all set on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_o[g] <= 1'b1;
            else if (wr_valid_i && wr_byte_i == BYTE_W'(BY) && wr_bit_i == 3'(BI))
                en_o[g] <= wr_val_i;
        end
    end

    AST_EN_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_o) |-> $past(wr_valid_i)); // R6
    AST_EN_ONE_BIT_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_o) |-> ($countones(en_o ^ $past(en_o)) == 1)); // R6
    AST_RESERVED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && !bit_is_mapped(3'(wr_byte_i), wr_bit_i)) |=> $stable(en_o)); // R8

endmodule

// File: rtl/clk_gate_bank.sv
// Gates the reference clock per output. Enables are retimed on the falling reference
// edge so they change only in the low phase. Assumes enables are quasi-static.
module clk_gate_bank #(
    parameter int NUM_OUT = 10
) (
    input  logic               ref_clk_i,
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] en_i,
    input  logic               oe_i,
    output logic [NUM_OUT-1:0] clk_out_o,
    output logic [NUM_OUT-1:0] clk_drive_o
);

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
        logic en_q;
        // Capture the enable in the low phase of the reference clock.
        always_ff @(negedge ref_clk_i) begin
            if (!rst_n) en_q <= 1'b1;
            else        en_q <= en_i[g];
        end
        assign clk_out_o[g]   = ref_clk_i & en_q;
        assign clk_drive_o[g] = oe_i;
    end

endmodule

// File: rtl/clk_fanout_cfg.sv
// Top: serial slave, enable bank and gated clock fan-out.
// Assumes clk is several times faster than SCL.
module clk_fanout_cfg #(
    parameter int         NUM_OUT     = 10,
    parameter int         SYNC_STAGES = 2,
    parameter int         DUMMY_BYTES = 2,
    parameter int         DATA_BYTES  = 7,
    parameter logic [7:0] DEV_ADDR    = 8'hD2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               ref_clk_i,
    input  logic               oe_i,
    output logic               sda_pull_o,
    output logic [NUM_OUT-1:0] clk_out_o,
    output logic [NUM_OUT-1:0] clk_drive_o
);

    localparam int BYTE_W = $clog2(DATA_BYTES);

    logic              scl_hi, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
    logic              wr_valid, wr_val;
    logic [BYTE_W-1:0] wr_byte;
    logic [2:0]        wr_bit;
    logic [NUM_OUT-1:0] en;

    bus_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_hi_o(scl_hi), .sda_lvl_o(sda_lvl), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_c), .stop_o(stop_c)
    );

    cfg_rx_fsm #(
        .DEV_ADDR(DEV_ADDR), .DUMMY_BYTES(DUMMY_BYTES),
        .DATA_BYTES(DATA_BYTES), .BYTE_W(BYTE_W)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .scl_hi_i(scl_hi), .sda_lvl_i(sda_lvl),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_c),
        .stop_i(stop_c), .ack_low_o(sda_pull_o), .wr_valid_o(wr_valid),
        .wr_byte_o(wr_byte), .wr_bit_o(wr_bit), .wr_val_o(wr_val)
    );

    en_bank #(.NUM_OUT(NUM_OUT), .BYTE_W(BYTE_W)) u_en (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_byte_i(wr_byte),
        .wr_bit_i(wr_bit), .wr_val_i(wr_val), .en_o(en)
    );

    clk_gate_bank #(.NUM_OUT(NUM_OUT)) u_gate (
        .ref_clk_i(ref_clk_i), .rst_n(rst_n), .en_i(en), .oe_i(oe_i),
        .clk_out_o(clk_out_o), .clk_drive_o(clk_drive_o)
    );

endmodule

// File: tb/tb_clk_fanout_cfg.sv
`timescale 1ns/1ps
module tb_clk_fanout_cfg;

    localparam int SCL_HALF = 6;
    localparam int REF_HALF = 33;

    logic       clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       oe = 1'b1;
    logic       sda_pull;
    logic [9:0] clk_out;
    logic [9:0] clk_drive;
    logic       sda_bus;

    int errors = 0;
    int checks = 0;
    int glitches = 0;
    logic [9:0] exp_en = 10'h3FF;
    bit done = 0;

    assign sda_bus = sda_m & ~sda_pull;

    clk_fanout_cfg dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .ref_clk_i(ref_clk), .oe_i(oe), .sda_pull_o(sda_pull),
        .clk_out_o(clk_out), .clk_drive_o(clk_drive)
    );

    always #10 clk = ~clk;
    always #(REF_HALF) ref_clk = ~ref_clk;

    // R9 monitor: an output must not move inside a reference high phase.
    always @(posedge ref_clk) begin
        logic [9:0] v;
        #1 v = clk_out;
        #(REF_HALF - 2);
        if (rst_n && clk_out !== v) glitches++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cond();
        sda_m = 1'b1; wt(SCL_HALF); scl = 1'b1; wt(SCL_HALF);
        sda_m = 1'b0; wt(SCL_HALF); scl = 1'b0; wt(SCL_HALF / 2);
    endtask

    task automatic stop_cond();
        sda_m = 1'b0; wt(SCL_HALF); scl = 1'b1; wt(SCL_HALF);
        sda_m = 1'b1; wt(SCL_HALF);
    endtask

    task automatic clock_bit(input logic b);
        sda_m = b; wt(SCL_HALF); scl = 1'b1; wt(SCL_HALF); scl = 1'b0; wt(SCL_HALF / 2);
    endtask

    task automatic ack_slot(input bit exp_ack, input string req);
        sda_m = 1'b1; wt(SCL_HALF); scl = 1'b1; wt(SCL_HALF / 2);
        check(sda_pull == exp_ack, req, 32'(sda_pull), 32'(exp_ack));
        wt(SCL_HALF - SCL_HALF / 2); scl = 1'b0; wt(SCL_HALF / 2);
    endtask

    // Expected output index for a data byte/bit, -1 when reserved (R8).
    function automatic int map_idx(input int db, input int bt);
        if (db == 0 && bt < 4) return bt;
        if (db == 1 && bt >= 4) return bt;
        if (db == 2 && bt == 2) return 8;
        if (db == 2 && bt == 3) return 9;
        return -1;
    endfunction

    // Sends bytes[1..n] after an address; the last byte is cut to last_bits bits.
    task automatic txn(input logic [7:0] addr, input int n, input int last_bits, input bit do_start);
        bit acc;
        if (do_start) start_cond();
        for (int b = 7; b >= 0; b--) clock_bit(addr[b]);
        acc = (addr == 8'hD2);
        ack_slot(acc, acc ? "R2 address ack" : "R4 bad address no ack");
        for (int j = 1; j <= n; j++) begin
            logic [7:0] v;
            int nb;
            v = 8'($urandom);
            nb = (j == n) ? last_bits : 8;
            for (int k = 0; k < nb; k++) begin
                clock_bit(v[7 - k]);
                if (acc && j >= 3 && j <= 9) begin
                    int ix;
                    ix = map_idx(j - 3, 7 - k);
                    if (ix >= 0) exp_en[ix] = v[7 - k];
                end
            end
            if (nb == 8) begin
                ack_slot(acc && j <= 9, (j > 9) ? "R12 no ack past last byte" : "R3 byte ack");
                if (j > 9) acc = 0;
            end
        end
    endtask

    task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string req);
        for (int b = 7; b >= 0; b--) clock_bit(v[b]);
        ack_slot(exp_ack, req);
    endtask

    task automatic check_outs(input string req);
        repeat (3) @(posedge ref_clk);
        @(posedge ref_clk); #3;
        check(clk_out === exp_en, req, 32'(clk_out), 32'(exp_en));
        @(negedge ref_clk); #3;
        check(clk_out === 10'h000, "R9 low phase", 32'(clk_out), 32'h0);
    endtask

    initial begin
        #3_800_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        wt(12);
        rst_n = 1'b1;
        wt(2);
        // R10 / R11: reset state
        check(clk_drive === 10'h3FF, "R11 drive with oe high", 32'(clk_drive), 32'h3FF);
        check(sda_pull === 1'b0, "R10 no ack at reset", 32'(sda_pull), 32'h0);
        check_outs("R10 all enabled after reset");

        // R5 R8 R12: full write, reserved bits set to 1, cmd/count arbitrary
        start_cond();
        send_byte(8'hD2, 1, "R2 address ack");
        send_byte(8'h03, 1, "R5 command byte acked");
        send_byte(8'h81, 1, "R5 count byte acked");
        send_byte(8'hF5, 1, "R3 data0 ack");
        send_byte(8'h3F, 1, "R3 data1 ack");
        send_byte(8'hF3, 1, "R3 data2 ack");
        for (int i = 0; i < 4; i++) send_byte(8'h00, 1, "R3 data3..6 ack");
        send_byte(8'h00, 0, "R12 no ack past data byte 6");
        stop_cond();
        exp_en = 10'b00_0011_0101;
        check_outs("R8 bit map and reserved bits");

        // R4: wrong address, following bytes ignored
        start_cond();
        send_byte(8'h52, 0, "R4 bad address no ack");
        for (int i = 0; i < 5; i++) send_byte(8'hFF, 0, "R4 ignored byte no ack");
        stop_cond();
        check_outs("R4 no change after bad address");

        // R1: bytes with no start after a stop
        send_byte(8'hD2, 0, "R1 no ack without start");
        send_byte(8'hFF, 0, "R1 no ack without start");
        stop_cond();
        check_outs("R1 no change without start");

        // R6 R7: commit mid byte, then stop
        start_cond();
        send_byte(8'hD2, 1, "R2 address ack");
        send_byte(8'h00, 1, "R5 command");
        send_byte(8'h00, 1, "R5 count");
        for (int k = 0; k < 6; k++) clock_bit(k >= 4);
        exp_en[3] = 1'b1; exp_en[2] = 1'b1;
        check_outs("R6 bits applied before byte end");
        stop_cond();
        check_outs("R7 untouched bits keep value after stop");

        // R7: repeated start mid data byte 1
        start_cond();
        send_byte(8'hD2, 1, "R2 address ack");
        send_byte(8'h00, 1, "R5 command");
        send_byte(8'h00, 1, "R5 count");
        send_byte(8'h00, 1, "R3 data0 ack");
        exp_en[3:0] = 4'h0;
        for (int k = 0; k < 2; k++) clock_bit(1'b1);
        exp_en[7] = 1'b1; exp_en[6] = 1'b1;
        start_cond();
        stop_cond();
        check_outs("R7 truncated by repeated start");

        // R11: output-enable pin
        oe = 1'b0; wt(2);
        check(clk_drive === 10'h000, "R11 tri-state with oe low", 32'(clk_drive), 32'h0);
        check_outs("R11 enables kept while oe low");
        oe = 1'b1; wt(2);
        check(clk_drive === 10'h3FF, "R11 drive restored", 32'(clk_drive), 32'h3FF);

        // Random transfers: length, truncation point, address and ending vary
        for (int t = 0; t < 36; t++) begin
            logic [7:0] a;
            int n, lb;
            bit rs;
            a  = ($urandom_range(0, 9) == 0) ? (8'hD2 ^ 8'($urandom_range(1, 255))) : 8'hD2;
            n  = $urandom_range(0, 11);
            lb = $urandom_range(0, 8);
            rs = 1'($urandom_range(0, 1));
            txn(a, n, lb, 1'b1);
            if (rs) start_cond();
            stop_cond();
            check_outs("R7 R8 random transfer");
        end

        check(glitches == 0, "R9 no change in high phase", 32'(glitches), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule